// File: doc/BRIEF.md
# Prioritised Interrupt Line Router

This block collects a wide vector of peripheral interrupt sources and steers each one onto one of 31 numbered CPU interrupt lines. For every source, software writes a small routing word naming the line that source drives; a routing word of zero leaves the source unconnected. Any number of sources may share a line, and the line then sees the OR of all of them.

Each line has four settings of its own: an enable bit, a trigger mode and a 4-bit priority, plus a pending state. In level mode the pending state simply follows the OR of the line's sources. In edge mode a rising edge of that OR sets a latch, and the latch stays set until software removes it with a clear write. A single global threshold hides every line whose priority is below it. From the lines that are pending, enabled, of non-zero priority and at or above the threshold, the block gives the CPU the one with the highest priority, as a valid flag and a 5-bit line number. Software can also read the raw level of every source as packed 32-bit status words.

All configuration goes through one word-addressed register port. Writes commit on the clock edge, and reads are combinational.

Top module: `irq_router`

## Requirements
- R1: After reset every routing word, the enable word, the mode word, the threshold and every line priority read back as 0, and irqValid is 0 whatever the sources do.
- R2: Routing word s sits at word address s, in bits [4:0]. Source s then drives the line with that number. A routing word of 0 connects the source to no line, and line 0 is never reported.
- R3: Enable word at address 0x80, where bit n allows line n to be reported. A pending line whose enable bit is 0 is never reported.
- R4: Priority of line n sits at address 0xA0+n, in bits [3:0], with 15 the highest. A line whose priority is 0 is never reported.
- R5: Threshold at address 0x82, in bits [3:0]. A line is reported only when its priority is greater than or equal to the threshold.
- R6: Mode word at address 0x81. Bit n = 0 puts line n in level mode, where its pending state follows the OR of its sources with no clock delay and drops when they drop.
- R7: Bit n = 1 of the mode word puts line n in edge mode. A rising edge of the line's source OR, seen at a clock edge, sets its pending latch, and the latch holds after the sources fall.
- R8: Writing 1 to bit n of address 0x83 removes the edge latch of line n at that clock edge. The write has no effect on a level-mode line. If a new rising edge arrives at the same edge as the clear, the line stays pending.
- R9: Among the reportable lines, irqLine names the one with the highest priority. On equal priority the lower line number wins.
- R10: Status word w at address 0x84+w holds the raw level of source 32*w+b in bit b. There are ceil(NUM_SRC/32) words.
- R11: A register write becomes visible, in the readback and in the routing, only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIrq | input | NUM_SRC | Raw peripheral interrupt sources |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Word address for both read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqValid | output | 1 | A reportable line exists |
| irqLine | output | 5 | Number of the winning line |

## Verification
The hard case is a clear write that lands on an edge-mode line in the same cycle as a fresh rising edge of that line's sources. The bench raises the source and issues the clear in one cycle. It then expects the line to remain pending after that edge, because the new event must not be lost. The bench also sends a clear to a level-mode line whose source is high, on top of an edge line being cleared at the same edge, and expects the level line to keep being reported.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int LINE_W    = 5;
  localparam int NUM_LINES = 1 << LINE_W;
  localparam int PRIO_W    = 4;
  localparam int DATA_W    = 32;
  localparam int IDX_W     = 7;

  localparam logic [7:0] ADDR_EN   = 8'h80;
  localparam logic [7:0] ADDR_MODE = 8'h81;
  localparam logic [7:0] ADDR_THR  = 8'h82;
  localparam logic [7:0] ADDR_CLR  = 8'h83;
  localparam logic [7:0] ADDR_STAT = 8'h84;
  localparam logic [7:0] ADDR_PRIO = 8'hA0;

  typedef enum logic [2:0] {
    RD_NONE, RD_MAP, RD_EN, RD_MODE, RD_THR, RD_STAT, RD_PRIO
  } rdSel_e;

  typedef struct packed {
    logic mapWr;
    logic enWr;
    logic modeWr;
    logic thrWr;
    logic clrWr;
    logic prioWr;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 48
) (
  input  logic             regWrEn,
  input  logic [7:0]       regAddr,
  output regStrobe_t       wrStb,
  output rdSel_e           rdSel,
  output logic [IDX_W-1:0] rdIdx
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;

  rdSel_e           sel;
  logic [IDX_W-1:0] idx;

  always_comb begin
    sel = RD_NONE;
    idx = '0;
    if (int'(regAddr) < NUM_SRC) begin
      sel = RD_MAP;
      idx = IDX_W'(regAddr);
    end else if (regAddr == ADDR_EN) begin
      sel = RD_EN;
    end else if (regAddr == ADDR_MODE) begin
      sel = RD_MODE;
    end else if (regAddr == ADDR_THR) begin
      sel = RD_THR;
    end else if (regAddr >= ADDR_STAT && int'(regAddr) < int'(ADDR_STAT) + NUM_WORDS) begin
      sel = RD_STAT;
      idx = IDX_W'(regAddr - ADDR_STAT);
    end else if (regAddr >= ADDR_PRIO && int'(regAddr) < int'(ADDR_PRIO) + NUM_LINES) begin
      sel = RD_PRIO;
      idx = IDX_W'(regAddr - ADDR_PRIO);
    end
  end

  always_comb begin
    wrStb        = '0;
    wrStb.idx    = idx;
    wrStb.mapWr  = regWrEn && (sel == RD_MAP);
    wrStb.enWr   = regWrEn && (sel == RD_EN);
    wrStb.modeWr = regWrEn && (sel == RD_MODE);
    wrStb.thrWr  = regWrEn && (sel == RD_THR);
    wrStb.prioWr = regWrEn && (sel == RD_PRIO);
    wrStb.clrWr  = regWrEn && (regAddr == ADDR_CLR);
  end

  assign rdSel = sel;
  assign rdIdx = idx;
endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb
  import irq_router_pkg::*;
(
  input  logic [NUM_LINES-1:0]        elig,
  input  logic [NUM_LINES*PRIO_W-1:0] prioFlat,
  output logic                        winValid,
  output logic [LINE_W-1:0]           winLine
);
  logic [PRIO_W-1:0] bestPrio;

  always_comb begin
    winValid = 1'b0;
    winLine  = '0;
    bestPrio = '0;
    // Scanning downward with >= lets the lower number take a tie.
    for (int n = NUM_LINES - 1; n >= 1; n--) begin
      if (elig[n] && prioFlat[n*PRIO_W +: PRIO_W] >= bestPrio) begin
        winValid = 1'b1;
        winLine  = LINE_W'(n);
        bestPrio = prioFlat[n*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 48
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          srcIrq,
  input  regStrobe_t                  wrStb,
  input  rdSel_e                      rdSel,
  input  logic [IDX_W-1:0]            rdIdx,
  input  logic [DATA_W-1:0]           wrData,
  output logic [DATA_W-1:0]           rdData,
  output logic                        irqValid,
  output logic [LINE_W-1:0]           irqLine,
  output logic [NUM_LINES-1:0]        enVec,
  output logic [NUM_LINES-1:0]        modeVec,
  output logic [NUM_LINES-1:0]        edgePend,
  output logic [PRIO_W-1:0]           thrVal,
  output logic [NUM_LINES*PRIO_W-1:0] prioFlat
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  logic [LINE_W-1:0]    mapReg  [NUM_SRC];
  logic [PRIO_W-1:0]    prioReg [NUM_LINES];
  logic [NUM_LINES-1:0] srcOr, srcOrPrev, riseVec, clrMask, pendVec, elig;
  logic [PAD_W-1:0]     statPad;

  // Routing words
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        mapReg[s] <= '0;
      else if (wrStb.mapWr && wrStb.idx == IDX_W'(s))
        mapReg[s] <= wrData[LINE_W-1:0];
    end
  end

  // Line priorities
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        prioReg[n] <= '0;
      else if (wrStb.prioWr && wrStb.idx == IDX_W'(n))
        prioReg[n] <= wrData[PRIO_W-1:0];
    end
    assign prioFlat[n*PRIO_W +: PRIO_W] = prioReg[n];
  end

  // Line-wide control words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec   <= '0;
      modeVec <= '0;
      thrVal  <= '0;
    end else begin
      if (wrStb.enWr)   enVec   <= wrData[NUM_LINES-1:0];
      if (wrStb.modeWr) modeVec <= wrData[NUM_LINES-1:0];
      if (wrStb.thrWr)  thrVal  <= wrData[PRIO_W-1:0];
    end
  end

  // OR of mapped sources per line; line 0 takes nothing
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_or
    if (n == 0) begin : g_zero
      assign srcOr[n] = 1'b0;
    end else begin : g_line
      always_comb begin
        srcOr[n] = 1'b0;
        for (int s = 0; s < NUM_SRC; s++)
          if (srcIrq[s] && mapReg[s] == LINE_W'(n)) srcOr[n] = 1'b1;
      end
    end
  end

  // Edge capture: a new rise wins over a clear at the same edge
  assign riseVec = srcOr & ~srcOrPrev;
  assign clrMask = wrStb.clrWr ? wrData[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcOrPrev <= '0;
      edgePend  <= '0;
    end else begin
      srcOrPrev <= srcOr;
      edgePend  <= modeVec & (riseVec | (edgePend & ~clrMask));
    end
  end

  assign pendVec = (modeVec & edgePend) | (~modeVec & srcOr);

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_elig
    assign elig[n] = pendVec[n] && enVec[n] && (prioReg[n] != '0) && (prioReg[n] >= thrVal);
  end

  irq_router_arb u_arb (
    .elig     (elig),
    .prioFlat (prioFlat),
    .winValid (irqValid),
    .winLine  (irqLine)
  );

  // Readback
  assign statPad = PAD_W'(srcIrq);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_MAP:
        for (int s = 0; s < NUM_SRC; s++)
          if (rdIdx == IDX_W'(s)) rdData = DATA_W'(mapReg[s]);
      RD_EN:   rdData = DATA_W'(enVec);
      RD_MODE: rdData = DATA_W'(modeVec);
      RD_THR:  rdData = DATA_W'(thrVal);
      RD_STAT:
        for (int w = 0; w < NUM_WORDS; w++)
          if (rdIdx == IDX_W'(w)) rdData = statPad[w*32 +: 32];
      RD_PRIO:
        for (int n = 0; n < NUM_LINES; n++)
          if (rdIdx == IDX_W'(n)) rdData = DATA_W'(prioReg[n]);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 48
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIrq,
  input  logic               regWrEn,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               irqValid,
  output logic [4:0]         irqLine
);
  regStrobe_t                  wrStb;
  rdSel_e                      rdSel;
  logic [IDX_W-1:0]            rdIdx;
  logic [NUM_LINES-1:0]        enVec, modeVec, edgePend;
  logic [PRIO_W-1:0]           thrVal;
  logic [NUM_LINES*PRIO_W-1:0] prioFlat;

  irq_router_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .rdIdx   (rdIdx)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIrq   (srcIrq),
    .wrStb    (wrStb),
    .rdSel    (rdSel),
    .rdIdx    (rdIdx),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqValid (irqValid),
    .irqLine  (irqLine),
    .enVec    (enVec),
    .modeVec  (modeVec),
    .edgePend (edgePend),
    .thrVal   (thrVal),
    .prioFlat (prioFlat)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        regWrEn,
  input logic [7:0]                  regAddr,
  input logic [31:0]                 regWrData,
  input logic                        irqValid,
  input logic [4:0]                  irqLine,
  input logic [NUM_LINES-1:0]        enVec,
  input logic [NUM_LINES-1:0]        modeVec,
  input logic [NUM_LINES-1:0]        edgePend,
  input logic [PRIO_W-1:0]           thrVal,
  input logic [NUM_LINES*PRIO_W-1:0] prioFlat
);
  logic [PRIO_W-1:0]    winPrio;
  logic [NUM_LINES-1:0] clrHit, holdMask;
  logic                 modeWrite;

  assign winPrio   = prioFlat[int'(irqLine)*PRIO_W +: PRIO_W];
  assign clrHit    = (regWrEn && regAddr == ADDR_CLR) ? regWrData : '0;
  assign modeWrite = regWrEn && regAddr == ADDR_MODE;

  // Latches that must survive the coming edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdMask <= '0;
    else       holdMask <= modeWrite ? '0 : (edgePend & modeVec & ~clrHit);
  end

  AST_NO_LINE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> irqLine != '0);                                       // R2
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> enVec[irqLine]);                                      // R3
  AST_WIN_PRIO_SET: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> winPrio != '0);                                       // R4
  AST_WIN_OVER_THR: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> winPrio >= thrVal);                                   // R5
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (holdMask & ~edgePend) == '0);                                     // R7
endmodule

bind irq_router irq_router_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .irqValid  (irqValid),
  .irqLine   (irqLine),
  .enVec     (enVec),
  .modeVec   (modeVec),
  .edgePend  (edgePend),
  .thrVal    (thrVal),
  .prioFlat  (prioFlat)
);

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int  NSRC   = 48;
  localparam time PERIOD = 10;

  typedef struct packed {
    logic [NSRC-1:0] src;
    logic            v;
    logic [4:0]      line;
  } vec_t;

  // Routing set up before the walk: src0->L3 p2, src1->L5 p7, src2->L7 p7,
  // src3->L9 p0, src4->L11 p9 (disabled), src40->L3, src41 unrouted.
  localparam vec_t VECS [10] = '{
    '{48'h0,            1'b0, 5'd0},
    '{48'h1,            1'b1, 5'd3},
    '{48'h2,            1'b1, 5'd5},
    '{48'h6,            1'b1, 5'd5},
    '{48'h4,            1'b1, 5'd7},
    '{48'h5,            1'b1, 5'd7},
    '{48'h8,            1'b0, 5'd0},
    '{48'h10,           1'b0, 5'd0},
    '{48'h0100_0000_0000, 1'b1, 5'd3},
    '{48'h0200_0000_0000, 1'b0, 5'd0}
  };
  localparam string VREQ [10] = '{"R1", "R2", "R2", "R9", "R2", "R9", "R4", "R3", "R2", "R2"};

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIrq = '0;
  logic            regWrEn = 1'b0;
  logic [7:0]      regAddr = '0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic            irqValid;
  logic [4:0]      irqLine;

  int errors = 0;
  int checks = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_router #(.NUM_SRC(NSRC)) i_irq_router (
    .clk, .rstN, .srcIrq, .regWrEn, .regAddr, .regWrData, .regRdData, .irqValid, .irqLine
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkIrq(input string req, input logic v, input logic [4:0] line);
    check(req, "irqValid", 32'(irqValid), 32'(v));
    if (v) check(req, "irqLine", 32'(irqLine), 32'(line));
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);

    // R1: reset state, sources active while held in reset
    srcIrq = '1;
    #1 checkIrq("R1", 1'b0, 5'd0);
    rstN = 1'b1;
    @(negedge clk);
    #1 checkIrq("R1", 1'b0, 5'd0);
    regRead(8'd0, rd);  check("R1", "map0", rd, 0);
    regRead(8'h80, rd); check("R1", "enable", rd, 0);
    regRead(8'h82, rd); check("R1", "threshold", rd, 0);
    regRead(8'hA5, rd); check("R1", "prio5", rd, 0);
    srcIrq = '0;

    // R11: write is visible only after the clock edge
    @(negedge clk);
    regAddr = 8'd0; regWrData = 32'd3; regWrEn = 1'b1;
    #1 check("R11", "map0 before edge", regRdData, 0);
    @(negedge clk);
    regWrEn = 1'b0;
    #1 check("R11", "map0 after edge", regRdData, 3);

    regWrite(8'd1, 5);  regWrite(8'd2, 7);  regWrite(8'd3, 9);
    regWrite(8'd4, 11); regWrite(8'd40, 3); regWrite(8'd41, 0);
    regWrite(8'hA3, 2); regWrite(8'hA5, 7); regWrite(8'hA7, 7);
    regWrite(8'hA9, 0); regWrite(8'hAB, 9);
    regWrite(8'h80, 32'h0000_02A8);
    regRead(8'h80, rd); check("R11", "enable readback", rd, 32'h2A8);
    regRead(8'hA5, rd); check("R11", "prio5 readback", rd, 7);

    // Table walk, level mode (R6 combinational path)
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      srcIrq = VECS[i].src;
      #1 checkIrq(VREQ[i], VECS[i].v, VECS[i].line);
    end

    // R6: level line drops together with its source
    @(negedge clk); srcIrq = 48'h2;
    #1 checkIrq("R6", 1'b1, 5'd5);
    srcIrq = '0;
    #1 checkIrq("R6", 1'b0, 5'd0);

    // R5: threshold
    srcIrq = 48'h1;
    regWrite(8'h82, 2); #1 checkIrq("R5", 1'b1, 5'd3);
    regWrite(8'h82, 3); #1 checkIrq("R5", 1'b0, 5'd0);
    srcIrq = 48'h2;
    regWrite(8'h82, 7); #1 checkIrq("R5", 1'b1, 5'd5);
    regWrite(8'h82, 8); #1 checkIrq("R5", 1'b0, 5'd0);
    regWrite(8'h82, 0);
    srcIrq = '0;

    // R7: line 7 in edge mode
    regWrite(8'h81, 32'h80);
    @(negedge clk); srcIrq = 48'h4;
    #1 checkIrq("R7", 1'b0, 5'd0);
    @(negedge clk); srcIrq = '0;
    #1 checkIrq("R7", 1'b1, 5'd7);
    repeat (3) @(negedge clk);
    #1 checkIrq("R7", 1'b1, 5'd7);

    // R8: clear removes the latch
    regWrite(8'h83, 32'h80);
    #1 checkIrq("R8", 1'b0, 5'd0);

    // R8: rise and clear at the same edge, the rise wins
    @(negedge clk);
    srcIrq = 48'h4;
    regAddr = 8'h83; regWrData = 32'h80; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 checkIrq("R8", 1'b1, 5'd7);

    // R8: clear on level line 5 has no effect, tie with 7 goes to 5 (R9)
    srcIrq = 48'h6;
    #1 checkIrq("R9", 1'b1, 5'd5);
    regWrite(8'h83, 32'hA0);
    #1 checkIrq("R8", 1'b1, 5'd5);
    srcIrq = 48'h4;
    #1 checkIrq("R8", 1'b0, 5'd0);
    srcIrq = '0;

    // R10: status words
    srcIrq = (48'h1 << 0) | (48'h1 << 33) | (48'h1 << 47);
    regRead(8'h84, rd); check("R10", "status0", rd, 32'h1);
    regRead(8'h85, rd); check("R10", "status1", rd, 32'h8002);
    srcIrq = '0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule